// File: doc/BRIEF.md
# Configurable Coincidence Trigger Unit

This block forms muon-style coincidence triggers from a wide vector of detector counter hits. It takes 50 top-counter hit lines and 48 side-counter hit lines, 98 channels in all, sampled on the block clock. Each channel is first shaped: its rising edge opens a gate of a common programmable length. After a channel has taken part in an issued trigger, it is held off for a common programmable lockout time.

Four identical trigger units watch the shaped channel vector. Each unit holds two channel groups. Each group has its own mask over both counter types. A group is reduced to one bit by a selectable rule (any, at least two, exactly one). The two group bits are then joined by a second rule (AND, OR, XOR). A rising edge of the joined result passes through a skip-count prescaler before the unit's strobe is issued. The outputs are one strobe bit per unit, collected as a type word, and a one-cycle valid flag that is set when any unit fires.

All settings come from a simple write-only register port. Output pulse stretching is left to the surrounding logic.

Top module: `coinc_trigger`

## Requirements
- R1: After reset all outputs are low and every setting is zero, so no unit fires even when every hit line is high.
- R2: Group rule code 1 asserts the group when at least one of its masked channels is active. The rule code sits in ctrl bits [5:4] for group 0 and bits [9:8] for group 1.
- R3: Group rule code 2 asserts the group only when two or more of its masked channels are active at once.
- R4: Group rule code 3 asserts the group only when exactly one masked channel is active. Code 0 never asserts.
- R5: The join code in ctrl bits [1:0] combines the two group bits: 0 = AND, 1 = OR, 2 = XOR. Code 3 never asserts.
- R6: A group whose mask is all zero never asserts, so a unit with both masks zero never fires.
- R7: With a gate length of 0, a channel is active exactly while its sampled hit line is high. A hit applied before clock edge k gives a strobe that is visible after edge k+1.
- R8: With a gate length W from 1 to 15, a rising hit edge makes the channel active for exactly W cycles. A new rising edge during the gate restarts it.
- R9: With a lockout L, every active channel in either mask of a unit that fires is held inactive for the next L cycles. A hit held high on such a channel therefore fires again every L+1 cycles.
- R10: A unit fires only on the rising edge of its joined result. The strobe lasts one cycle, and the result must fall before the unit can fire again.
- R11: With prescale P (ctrl bits [23:16]), the first qualifying edge after reset fires. The next P qualifying edges are skipped, and the pattern then repeats.
- R12: Bit t of trig_type is the strobe of unit t. trig_valid is high in the same cycle exactly when any bit of trig_type is high.
- R13: Register map, 7-bit word address. Address 0: bits [3:0] gate length, bits [13:8] lockout. Unit t has base address 16*(t+1). Base+0 is ctrl. Base+1..+4 hold group 0 mask words, and base+5..+8 hold group 1 mask words. Mask word w holds channel bits 32w..32w+31, where channels 0-49 are top counters and 50-97 are side counters. Writes take effect after the clock edge that captures them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset, also starts a run |
| top_hits | input | 50 | Top-counter hit lines |
| side_hits | input | 48 | Side-counter hit lines |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| trig_valid | output | 1 | One-cycle flag: some unit fired |
| trig_type | output | 4 | Per-unit strobe bits |

## Verification
A stale gate or lockout counter in a channel would change a unit's firing within a few cycles. It would show either as a coincidence that fires when the pulses do not overlap, or as a held hit that repeats at a period other than L+1. A prescale counter left in the wrong state would shift which pulse in a train fires, and this is visible from the first pulse after reset. An edge detector that fails to clear would produce repeated strobes while an input is held high. A misdecoded register would leave a unit silent or firing on the wrong channels as soon as a hit arrives.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

    localparam int TOP_CH      = 50;
    localparam int SIDE_CH     = 48;
    localparam int N_CH        = TOP_CH + SIDE_CH;
    localparam int WIN_W       = 4;
    localparam int LOCK_W      = 6;
    localparam int PS_W        = 8;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 7;
    localparam int N_WORDS     = (N_CH + DATA_W - 1) / DATA_W;
    localparam int UNIT_STRIDE = 16;

    typedef enum logic [1:0] {
        RULE_OFF    = 2'd0,
        RULE_ANY    = 2'd1,
        RULE_MULTI  = 2'd2,
        RULE_SINGLE = 2'd3
    } rule_e;

    typedef enum logic [1:0] {
        JOIN_AND = 2'd0,
        JOIN_OR  = 2'd1,
        JOIN_XOR = 2'd2,
        JOIN_OFF = 2'd3
    } join_e;

    typedef struct packed {
        logic [WIN_W-1:0]  window;
        logic [LOCK_W-1:0] lockout;
    } glob_cfg_t;

    typedef struct packed {
        logic [PS_W-1:0] prescale;
        rule_e           rule0;
        rule_e           rule1;
        join_e           join_op;
        logic [N_CH-1:0] mask0;
        logic [N_CH-1:0] mask1;
    } unit_cfg_t;

    // Reduce a masked channel vector to one bit by the chosen rule.
    function automatic logic reduce_group(input rule_e r, input logic [N_CH-1:0] v);
        logic any_on;
        logic multi_on;
        any_on   = |v;
        multi_on = |(v & (v - N_CH'(1)));
        case (r)
            RULE_ANY:    return any_on;
            RULE_MULTI:  return multi_on;
            RULE_SINGLE: return any_on & ~multi_on;
            default:     return 1'b0;
        endcase
    endfunction

    function automatic logic join_groups(input join_e j, input logic a, input logic b);
        case (j)
            JOIN_AND: return a & b;
            JOIN_OR:  return a | b;
            JOIN_XOR: return a ^ b;
            default:  return 1'b0;
        endcase
    endfunction

    // Replace one data word of a channel mask.
    function automatic logic [N_CH-1:0] put_word(input logic [N_CH-1:0] m, input int w,
                                                 input logic [DATA_W-1:0] d);
        logic [N_CH-1:0] r;
        r = m;
        for (int i = 0; i < DATA_W; i++) begin
            if (w * DATA_W + i < N_CH) r[w * DATA_W + i] = d[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/coinc_cfg.sv
module coinc_cfg
    import coinc_pkg::*;
#(
    parameter int N_TRIG = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output glob_cfg_t                glob,
    output unit_cfg_t [N_TRIG-1:0]   ucfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            glob <= '0;
            ucfg <= '0;
        end else if (wr) begin
            if (addr == '0) begin
                glob.window  <= wdata[WIN_W-1:0];
                glob.lockout <= wdata[8 +: LOCK_W];
            end
            for (int t = 0; t < N_TRIG; t++) begin
                if (addr == ADDR_W'(UNIT_STRIDE * (t + 1))) begin
                    ucfg[t].join_op  <= join_e'(wdata[1:0]);
                    ucfg[t].rule0    <= rule_e'(wdata[5:4]);
                    ucfg[t].rule1    <= rule_e'(wdata[9:8]);
                    ucfg[t].prescale <= wdata[16 +: PS_W];
                end
                for (int w = 0; w < N_WORDS; w++) begin
                    if (addr == ADDR_W'(UNIT_STRIDE * (t + 1) + 1 + w))
                        ucfg[t].mask0 <= put_word(ucfg[t].mask0, w, wdata);
                    if (addr == ADDR_W'(UNIT_STRIDE * (t + 1) + 1 + N_WORDS + w))
                        ucfg[t].mask1 <= put_word(ucfg[t].mask1, w, wdata);
                end
            end
        end
    end

    // R13
    cfg_window_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == '0) |=> glob.window == $past(wdata[WIN_W-1:0]));

endmodule

// File: rtl/coinc_chan.sv
module coinc_chan
    import coinc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              raw,
    input  logic [WIN_W-1:0]  win,
    input  logic [LOCK_W-1:0] lock_len,
    input  logic              lock_hit,
    output logic              active_o
);

    logic              in_q;
    logic              in_d;
    logic [WIN_W-1:0]  str_cnt;
    logic [LOCK_W-1:0] lock_cnt;
    logic              rise;
    logic              gate;

    assign rise     = in_q & ~in_d;
    assign gate     = (win == '0) ? in_q : (rise | (str_cnt != '0));
    assign active_o = gate & (lock_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q     <= 1'b0;
            in_d     <= 1'b0;
            str_cnt  <= '0;
            lock_cnt <= '0;
        end else begin
            in_q <= raw;
            in_d <= in_q;
            if (win == '0)
                str_cnt <= '0;
            else if (rise)
                str_cnt <= win - 1'b1;
            else if (str_cnt != '0)
                str_cnt <= str_cnt - 1'b1;
            if (lock_hit && active_o)
                lock_cnt <= lock_len;
            else if (lock_cnt != '0)
                lock_cnt <= lock_cnt - 1'b1;
        end
    end

    // R8
    gate_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate) |-> in_q);

    // R9
    lock_block_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_hit && active_o && lock_len != '0) |=> !active_o);

endmodule

// File: rtl/coinc_unit.sv
module coinc_unit
    import coinc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] active,
    input  unit_cfg_t       cfg,
    output logic            fire,
    output logic            strobe
);

    logic            grp0;
    logic            grp1;
    logic            result;
    logic            res_q;
    logic            rise;
    logic [PS_W-1:0] ps_cnt;

    assign grp0   = reduce_group(cfg.rule0, active & cfg.mask0);
    assign grp1   = reduce_group(cfg.rule1, active & cfg.mask1);
    assign result = join_groups(cfg.join_op, grp0, grp1);
    assign rise   = result & ~res_q;
    assign fire   = rise && (ps_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= 1'b0;
            ps_cnt <= '0;
            strobe <= 1'b0;
        end else begin
            res_q  <= result;
            strobe <= fire;
            if (rise)
                ps_cnt <= (ps_cnt == '0) ? cfg.prescale : ps_cnt - 1'b1;
        end
    end

    // R10
    strobe_once_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    // R10
    strobe_result_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |-> res_q);

endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
    import coinc_pkg::*;
#(
    parameter int N_TRIG = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TOP_CH-1:0]   top_hits,
    input  logic [SIDE_CH-1:0]  side_hits,
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic                trig_valid,
    output logic [N_TRIG-1:0]   trig_type
);

    glob_cfg_t               glob;
    unit_cfg_t [N_TRIG-1:0]  ucfg;
    logic [N_CH-1:0]         raw;
    logic [N_CH-1:0]         active;
    logic [N_CH-1:0]         involve;
    logic [N_TRIG-1:0]       fire;

    assign raw = {side_hits, top_hits};

    coinc_cfg #(.N_TRIG(N_TRIG)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .glob  (glob),
        .ucfg  (ucfg)
    );

    always_comb begin
        involve = '0;
        for (int t = 0; t < N_TRIG; t++) begin
            if (fire[t]) involve = involve | ucfg[t].mask0 | ucfg[t].mask1;
        end
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        coinc_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .raw      (raw[c]),
            .win      (glob.window),
            .lock_len (glob.lockout),
            .lock_hit (involve[c]),
            .active_o (active[c])
        );
    end

    for (genvar t = 0; t < N_TRIG; t++) begin : g_unit
        coinc_unit u_unit (
            .clk    (clk),
            .rst    (rst),
            .active (active),
            .cfg    (ucfg[t]),
            .fire   (fire[t]),
            .strobe (trig_type[t])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) trig_valid <= 1'b0;
        else     trig_valid <= |fire;
    end

    // R12
    valid_type_chk: assert property (@(posedge clk) disable iff (rst)
        trig_valid == (trig_type != '0));

endmodule

// File: tb/coinc_trigger_test.sv
module coinc_trigger_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [49:0] top_hits;
    logic [47:0] side_hits;
    logic        cfg_wr;
    logic [6:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        trig_valid;
    logic [3:0]  trig_type;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int nf [4]   = '{0, 0, 0, 0};
    int last0    = 0;
    int prev0    = 0;
    int base0;
    bit done     = 0;

    // vector: {expect, join, rule0, rule1, group0 hits, group1 hits}
    localparam logic [14:0] VEC [12] = '{
        {1'b1, 2'd0, 2'd1, 2'd1, 4'h1, 4'h1},
        {1'b0, 2'd0, 2'd1, 2'd1, 4'h1, 4'h0},
        {1'b1, 2'd1, 2'd1, 2'd1, 4'h0, 4'h2},
        {1'b0, 2'd2, 2'd1, 2'd1, 4'h1, 4'h1},
        {1'b1, 2'd2, 2'd1, 2'd1, 4'h1, 4'h0},
        {1'b1, 2'd1, 2'd2, 2'd1, 4'h3, 4'h0},
        {1'b0, 2'd1, 2'd2, 2'd1, 4'h1, 4'h0},
        {1'b1, 2'd1, 2'd3, 2'd1, 4'h4, 4'h0},
        {1'b0, 2'd1, 2'd3, 2'd1, 4'h5, 4'h0},
        {1'b0, 2'd1, 2'd0, 2'd1, 4'hF, 4'h0},
        {1'b0, 2'd3, 2'd1, 2'd1, 4'h1, 4'h1},
        {1'b1, 2'd1, 2'd2, 2'd1, 4'hF, 4'h0}
    };

    always #(CLK_PERIOD / 2) clk = ~clk;

    coinc_trigger uut (
        .clk        (clk),
        .rst        (rst),
        .top_hits   (top_hits),
        .side_hits  (side_hits),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .trig_valid (trig_valid),
        .trig_type  (trig_type)
    );

    always begin
        @(posedge clk);
        #1;
        cyc++;
        for (int t = 0; t < 4; t++) if (trig_type[t]) nf[t]++;
        if (trig_type[0]) begin
            prev0 = last0;
            last0 = cyc;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        cfg_wr    = 1'b1;
        cfg_addr  = 7'(a);
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    function automatic logic [31:0] ctrl(input int ps, input int r0, input int r1, input int j);
        return (32'(ps) << 16) | (32'(r1) << 8) | (32'(r0) << 4) | 32'(j);
    endfunction

    task automatic clear_hits();
        top_hits  = '0;
        side_hits = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        rst = 1'b1;
        cfg_wr = 1'b0;
        cfg_addr = '0;
        cfg_wdata = '0;
        clear_hits();
        ticks(3);
        check(trig_valid == 1'b0 && trig_type == 4'h0, "R1 reset outputs",
              int'({trig_valid, trig_type}), 0);
        rst = 1'b0;

        // R1: zero config, all hits high
        base0 = nf[0] + nf[1] + nf[2] + nf[3];
        top_hits  = '1;
        side_hits = '1;
        ticks(6);
        check(nf[0] + nf[1] + nf[2] + nf[3] == base0, "R1 no fire after reset",
              nf[0] + nf[1] + nf[2] + nf[3] - base0, 0);
        clear_hits();
        ticks(3);

        // R13: unit 0 masks, group0 = top 0..3, group1 = side 0..3 (channels 50..53)
        wr(17, 32'h0000_000F);
        wr(22, 32'h003C_0000);

        for (int v = 0; v < 12; v++) begin
            string tag;
            logic  exp;
            exp = VEC[v][14];
            wr(16, ctrl(0, int'(VEC[v][11:10]), int'(VEC[v][9:8]), int'(VEC[v][13:12])));
            if (VEC[v][11:10] == 2'd2)      tag = "R3";
            else if (VEC[v][11:10] != 2'd1) tag = "R4";
            else if (VEC[v][13:12] != 2'd1) tag = "R5";
            else                            tag = "R2";
            top_hits[3:0]  = VEC[v][7:4];
            side_hits[3:0] = VEC[v][3:0];
            ticks(2);
            check(trig_valid == exp && trig_type == {3'b000, exp},
                  $sformatf("%s R7 vector %0d", tag, v),
                  int'({trig_valid, trig_type}), exp ? 17 : 0);
            clear_hits();
            ticks(3);
        end

        // R6: unit 1 enabled with empty masks
        wr(16, 32'h0);
        wr(32, ctrl(0, 1, 1, 1));
        base0 = nf[1];
        top_hits  = '1;
        side_hits = '1;
        ticks(6);
        check(nf[1] == base0, "R6 empty masks", nf[1] - base0, 0);
        clear_hits();
        wr(32, 32'h0);
        ticks(3);

        // R10: held result fires once, re-arms after falling
        wr(16, ctrl(0, 1, 0, 1));
        base0 = nf[0];
        top_hits[0] = 1'b1;
        ticks(10);
        check(nf[0] - base0 == 1, "R10 held input", nf[0] - base0, 1);
        top_hits[0] = 1'b0;
        ticks(3);
        top_hits[0] = 1'b1;
        ticks(3);
        check(nf[0] - base0 == 2, "R10 re-arm", nf[0] - base0, 2);
        top_hits[0] = 1'b0;
        ticks(3);

        // R12: unit 2 watches top channel 0 only
        wr(49, 32'h0000_0001);
        wr(48, ctrl(0, 1, 0, 1));
        top_hits[0] = 1'b1;
        ticks(2);
        check(trig_valid && trig_type == 4'b0101, "R12 R13 two units",
              int'({trig_valid, trig_type}), 21);
        top_hits[0] = 1'b0;
        ticks(3);
        top_hits[1] = 1'b1;
        ticks(2);
        check(trig_valid && trig_type == 4'b0001, "R12 one unit",
              int'({trig_valid, trig_type}), 17);
        top_hits[1] = 1'b0;
        wr(48, 32'h0);
        ticks(3);

        // R7: no stretching with window 0
        wr(16, ctrl(0, 2, 0, 1));
        base0 = nf[0];
        top_hits[0] = 1'b1;
        ticks(1);
        top_hits[0] = 1'b0;
        top_hits[1] = 1'b1;
        ticks(1);
        top_hits[1] = 1'b0;
        ticks(6);
        check(nf[0] == base0, "R7 raw level no overlap", nf[0] - base0, 0);

        // R8: window 3
        wr(0, 32'h0000_0003);
        base0 = nf[0];
        top_hits[0] = 1'b1;
        ticks(1);
        top_hits[0] = 1'b0;
        ticks(1);
        top_hits[1] = 1'b1;
        ticks(1);
        top_hits[1] = 1'b0;
        ticks(8);
        check(nf[0] - base0 == 1, "R8 overlap inside window", nf[0] - base0, 1);
        base0 = nf[0];
        top_hits[0] = 1'b1;
        ticks(1);
        top_hits[0] = 1'b0;
        ticks(2);
        top_hits[1] = 1'b1;
        ticks(1);
        top_hits[1] = 1'b0;
        ticks(8);
        check(nf[0] == base0, "R8 gap past window", nf[0] - base0, 0);

        // R9: lockout 5, held hit repeats every 6 cycles
        wr(0, 32'h0000_0500);
        wr(16, ctrl(0, 1, 0, 1));
        base0 = nf[0];
        top_hits[0] = 1'b1;
        ticks(9);
        top_hits[0] = 1'b0;
        ticks(4);
        check(nf[0] - base0 == 2, "R9 lockout fire count", nf[0] - base0, 2);
        check(last0 - prev0 == 6, "R9 lockout period", last0 - prev0, 6);
        wr(0, 32'h0);
        ticks(3);

        // R11: prescale 2 over seven pulses
        wr(16, ctrl(2, 1, 0, 1));
        base0 = nf[0];
        for (int p = 0; p < 7; p++) begin
            top_hits[0] = 1'b1;
            ticks(1);
            top_hits[0] = 1'b0;
            ticks(3);
            if (p == 0)
                check(nf[0] - base0 == 1, "R11 first issued", nf[0] - base0, 1);
        end
        check(nf[0] - base0 == 3, "R11 prescale count", nf[0] - base0, 3);

        summary();
    end

endmodule